// File: doc/BRIEF.md
# Card Interface Host Register Port

This block is the host side of a smart-card interface controller. It is a fast-mode I2C slave with one 8-bit control register that the host writes and one 8-bit status register that the host reads. No register pointer exists. The direction flag in the address byte alone selects the register. Three strap inputs pick one of eight bus addresses, so up to eight interfaces can share one bus.

The control byte goes straight to the card sequencer. The sequencer clears the warm-reset bit once the card answers or is declared mute. The status byte mixes live levels (card present, I/O line level, card active) with sticky event flags raised by the sequencer and the fault monitors. A status read clears the sticky flags. An active-low interrupt stays asserted while any sticky flag is set or a supply fault is present, so a status read is also how the host acknowledges the interrupt.

SCL and SDA are synchronised to the system clock and treated as sampled signals. The block only pulls SDA low, through an open-drain enable output.

Top module: `cardif_host_regs`

## Requirements
- R1: The slave answers only an address byte whose upper seven bits equal 0x20 + {sel2,sel1,sel0}, so the 8-bit address byte is 0x40 + 2×sel with bit 0 the read flag. A mismatching address gets no ACK, and the rest of that transaction leaves the control register unchanged.
- R2: START, address with bit 0 = 0, ACK, one data byte, ACK, STOP. The slave acknowledges both bytes, and the data byte appears on the control output.
- R3: START, address with bit 0 = 1, ACK. The slave then shifts out the status byte MSB first, and the master NACKs before STOP. Status bit layout: bit7 card active (live), bit6 early answer, bit5 mute answer, bit4 over-current/over-temperature, bit3 supply fault, bit2 I/O line level (live), bit1 presence changed, bit0 card present (live).
- R4: After reset, the control register reads 0x00, SDA is released, and the interrupt output is high. With the I/O line high and no card, the status reads 0x04.
- R5: A rising or a falling edge on the card-present input sets the presence-changed flag (bit1).
- R6: Status bits 1, 3, 4, 5 and 6 are sticky and clear when the status register is read. Bits 5 and 6 also clear on a new-session pulse.
- R7: The interrupt output is low while any sticky flag is set or the supply-fault input is high. It returns high once a read has cleared the flags and the fault is gone.
- R8: A clear pulse from the sequencer resets control bit1 (warm reset). The other control bits are unaffected.
- R9: A read clears only the flags it returned, and only after the last data bit has been shifted out. An event that arrives during the read is still set for the next read.
- R10: START and STOP are SDA edges while SCL is high. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| addr_sel_i | input | 3 | Address strap inputs |
| ctrl_o | output | 8 | Control register contents |
| warm_clr_i | input | 1 | Sequencer pulse clearing control bit1 |
| session_start_i | input | 1 | New card session pulse, clears bits 5 and 6 |
| card_present_i | input | 1 | Card presence level |
| io_level_i | input | 1 | Card I/O line level |
| card_active_i | input | 1 | Card supply on |
| supply_fault_i | input | 1 | Supply fault level |
| prot_evt_i | input | 1 | Over-current or over-temperature event pulse |
| mute_evt_i | input | 1 | Card did not answer in time, pulse |
| early_evt_i | input | 1 | Card answered too early, pulse |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The assertions assume a well-behaved bus master. It moves SDA only while SCL is low, except to form START and STOP. Each SCL phase lasts well beyond the synchroniser delay. A STOP or repeated START never arrives while the slave holds SDA low. The bench master holds each SCL phase for sixteen system clocks and changes its data only in the low phase. It always NACKs the single status byte, so the slave's drive changes fall inside SCL-low windows. The status and control inputs are driven between system clock edges, and event inputs are single-cycle pulses.

// File: rtl/cardif_pkg.sv
package cardif_pkg;

    localparam int BYTE_W = 8;

    // status bit positions
    localparam int SB_PRES  = 0;
    localparam int SB_PCHG  = 1;
    localparam int SB_IO    = 2;
    localparam int SB_SUPL  = 3;
    localparam int SB_PROT  = 4;
    localparam int SB_MUTE  = 5;
    localparam int SB_EARLY = 6;
    localparam int SB_ACT   = 7;

    localparam logic [BYTE_W-1:0] STICKY_MASK = 8'b0111_1010;
    localparam logic [BYTE_W-1:0] SESSION_CLR = 8'b0110_0000;
    localparam logic [BYTE_W-1:0] CTRL_RST    = 8'h00;

    // control bit positions
    localparam int CB_WARM = 1;

    typedef enum logic [3:0] {
        BS_IDLE,
        BS_ADDR,
        BS_ADDR_CHK,
        BS_ADDR_ACK,
        BS_WDATA,
        BS_WDATA_CHK,
        BS_WDATA_ACK,
        BS_RDATA,
        BS_RACK,
        BS_HOLD
    } bus_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic logic addr_hit(input logic [6:0] rx_addr,
                                      input logic [6:0] base,
                                      input logic [6:0] offs);
        return rx_addr == (base + offs);
    endfunction

endpackage

// File: rtl/cardif_line_sync.sv
module cardif_line_sync
    import cardif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     scl_s_o,
    output line_ev_t ev_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_p, sda_p;
    logic scl_d, sda_d;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p[g] <= 1'b1;
                    sda_p[g] <= 1'b1;
                end else begin
                    scl_p[g] <= scl_i;
                    sda_p[g] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p[g] <= 1'b1;
                    sda_p[g] <= 1'b1;
                end else begin
                    scl_p[g] <= scl_p[g-1];
                    sda_p[g] <= sda_p[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_p[LAST];
            sda_d <= sda_p[LAST];
        end
    end

    always_comb begin
        scl_s_o       = scl_p[LAST];
        ev_o.sda      = sda_p[LAST];
        ev_o.scl_rise = scl_p[LAST] & ~scl_d;
        ev_o.scl_fall = ~scl_p[LAST] & scl_d;
        ev_o.start    = scl_p[LAST] & scl_d & sda_d & ~sda_p[LAST];
        ev_o.stop     = scl_p[LAST] & scl_d & ~sda_d & sda_p[LAST];
    end

endmodule

// File: rtl/cardif_byte_fsm.sv
module cardif_byte_fsm
    import cardif_pkg::*;
#(
    parameter int         SEL_W     = 3,
    parameter logic [6:0] ADDR_BASE = 7'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev_i,
    input  logic [SEL_W-1:0]  addr_sel_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_done_o,
    output logic [BYTE_W-1:0] rd_snap_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    bus_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_q, tx_q, snap_q;
    logic              rw_q, oe_q, wr_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BS_IDLE;
            cnt_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            snap_q  <= '0;
            rw_q    <= 1'b0;
            oe_q    <= 1'b0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            wr_q   <= 1'b0;
            done_q <= 1'b0;
            if (ev_i.stop) begin
                state_q <= BS_IDLE;
                oe_q    <= 1'b0;
            end else if (ev_i.start) begin
                state_q <= BS_ADDR;
                cnt_q   <= '0;
                oe_q    <= 1'b0;
            end else begin
                unique case (state_q)
                    BS_ADDR, BS_WDATA: begin
                        if (ev_i.scl_rise) begin
                            rx_q  <= {rx_q[BYTE_W-2:0], ev_i.sda};
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == CNT_LAST)
                                state_q <= (state_q == BS_ADDR) ? BS_ADDR_CHK : BS_WDATA_CHK;
                        end
                    end
                    BS_ADDR_CHK: begin
                        if (ev_i.scl_fall) begin
                            if (addr_hit(rx_q[7:1], ADDR_BASE, 7'(addr_sel_i))) begin
                                oe_q    <= 1'b1;
                                rw_q    <= rx_q[0];
                                state_q <= BS_ADDR_ACK;
                            end else begin
                                state_q <= BS_IDLE;
                            end
                        end
                    end
                    BS_ADDR_ACK: begin
                        if (ev_i.scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                tx_q    <= status_i;
                                snap_q  <= status_i;
                                oe_q    <= ~status_i[BYTE_W-1];
                                state_q <= BS_RDATA;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= BS_WDATA;
                            end
                        end
                    end
                    BS_WDATA_CHK: begin
                        if (ev_i.scl_fall) begin
                            oe_q    <= 1'b1;
                            wr_q    <= 1'b1;
                            state_q <= BS_WDATA_ACK;
                        end
                    end
                    BS_WDATA_ACK: begin
                        if (ev_i.scl_fall) begin
                            oe_q    <= 1'b0;
                            state_q <= BS_HOLD;
                        end
                    end
                    BS_RDATA: begin
                        if (ev_i.scl_fall) begin
                            if (cnt_q == CNT_LAST) begin
                                oe_q    <= 1'b0;
                                done_q  <= 1'b1;
                                state_q <= BS_RACK;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                                oe_q  <= ~tx_q[BYTE_W-2];
                            end
                        end
                    end
                    BS_RACK: begin
                        if (ev_i.scl_rise)
                            state_q <= BS_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o  = oe_q;
    assign wr_en_o   = wr_q;
    assign wr_data_o = rx_q;
    assign rd_done_o = done_q;
    assign rd_snap_o = snap_q;

endmodule

// File: rtl/cardif_reg_bank.sv
module cardif_reg_bank
    import cardif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              warm_clr_i,
    input  logic              rd_done_i,
    input  logic [BYTE_W-1:0] rd_snap_i,
    input  logic              session_start_i,
    input  logic              card_present_i,
    input  logic              io_level_i,
    input  logic              card_active_i,
    input  logic              supply_fault_i,
    input  logic              prot_evt_i,
    input  logic              mute_evt_i,
    input  logic              early_evt_i,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] status_o,
    output logic              irq_n_o
);
    logic [BYTE_W-1:0] ctrl_q, sticky_q, set_v, clr_v;
    logic              pres_q;

    always_comb begin
        set_v           = '0;
        set_v[SB_PCHG]  = card_present_i ^ pres_q;
        set_v[SB_SUPL]  = supply_fault_i;
        set_v[SB_PROT]  = prot_evt_i;
        set_v[SB_MUTE]  = mute_evt_i;
        set_v[SB_EARLY] = early_evt_i;
        clr_v = (rd_done_i ? (rd_snap_i & STICKY_MASK) : '0)
              | (session_start_i ? SESSION_CLR : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            sticky_q <= '0;
            pres_q   <= 1'b0;
        end else begin
            pres_q   <= card_present_i;
            sticky_q <= ((sticky_q & ~clr_v) | set_v) & STICKY_MASK;
            if (wr_en_i)
                ctrl_q <= wr_data_i;
            else if (warm_clr_i)
                ctrl_q[CB_WARM] <= 1'b0;
        end
    end

    always_comb begin
        status_o           = sticky_q;
        status_o[SB_PRES]  = card_present_i;
        status_o[SB_IO]    = io_level_i;
        status_o[SB_ACT]   = card_active_i;
    end

    assign ctrl_o  = ctrl_q;
    assign irq_n_o = ~((|sticky_q) | supply_fault_i);

endmodule

// File: rtl/cardif_host_regs.sv
module cardif_host_regs
    import cardif_pkg::*;
#(
    parameter int         SEL_W       = 3,
    parameter logic [6:0] ADDR_BASE   = 7'h20,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [SEL_W-1:0]  addr_sel_i,
    output logic [BYTE_W-1:0] ctrl_o,
    input  logic              warm_clr_i,
    input  logic              session_start_i,
    input  logic              card_present_i,
    input  logic              io_level_i,
    input  logic              card_active_i,
    input  logic              supply_fault_i,
    input  logic              prot_evt_i,
    input  logic              mute_evt_i,
    input  logic              early_evt_i,
    output logic              irq_n_o
);
    line_ev_t          ev;
    logic              scl_s;
    logic              wr_en, rd_done;
    logic [BYTE_W-1:0] wr_data, rd_snap, status;

    cardif_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_s_o (scl_s),
        .ev_o    (ev)
    );

    cardif_byte_fsm #(.SEL_W(SEL_W), .ADDR_BASE(ADDR_BASE)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .addr_sel_i (addr_sel_i),
        .status_i   (status),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .rd_done_o  (rd_done),
        .rd_snap_o  (rd_snap)
    );

    cardif_reg_bank u_regs (
        .clk             (clk),
        .rst             (rst),
        .wr_en_i         (wr_en),
        .wr_data_i       (wr_data),
        .warm_clr_i      (warm_clr_i),
        .rd_done_i       (rd_done),
        .rd_snap_i       (rd_snap),
        .session_start_i (session_start_i),
        .card_present_i  (card_present_i),
        .io_level_i      (io_level_i),
        .card_active_i   (card_active_i),
        .supply_fault_i  (supply_fault_i),
        .prot_evt_i      (prot_evt_i),
        .mute_evt_i      (mute_evt_i),
        .early_evt_i     (early_evt_i),
        .ctrl_o          (ctrl_o),
        .status_o        (status),
        .irq_n_o         (irq_n_o)
    );

endmodule

// File: rtl/cardif_host_regs_chk.sv
module cardif_host_regs_chk
    import cardif_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              sda_oe_o,
    input logic [BYTE_W-1:0] ctrl_o,
    input logic [BYTE_W-1:0] status,
    input logic              wr_en,
    input logic              warm_clr_i,
    input logic              session_start_i,
    input logic              early_evt_i,
    input logic              supply_fault_i,
    input logic              irq_n_o
);
    // R4
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ctrl_o == CTRL_RST && !sda_oe_o));

    // R1
    ctrl_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ctrl_o) && !$past(rst)) |-> $past(wr_en || warm_clr_i));

    // R8
    warm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_clr_i && !wr_en) |=> !ctrl_o[CB_WARM]);

    // R6
    session_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (session_start_i && !early_evt_i) |=> !status[SB_EARLY]);

    // R7
    fault_irq_chk: assert property (@(posedge clk) disable iff (rst)
        supply_fault_i |-> !irq_n_o);

    // R10
    sda_in_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_s);

endmodule

bind cardif_host_regs cardif_host_regs_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .scl_s           (scl_s),
    .sda_oe_o        (sda_oe_o),
    .ctrl_o          (ctrl_o),
    .status          (status),
    .wr_en           (wr_en),
    .warm_clr_i      (warm_clr_i),
    .session_start_i (session_start_i),
    .early_evt_i     (early_evt_i),
    .supply_fault_i  (supply_fault_i),
    .irq_n_o         (irq_n_o)
);

// File: tb/cardif_host_regs_tb.sv
module cardif_host_regs_tb;
    localparam int CLK_P = 10;
    localparam int HALF  = 16;
    localparam logic [6:0] MY_ADDR  = 7'h25; // 0x40 + 2*5 -> 0x4A byte
    localparam logic [6:0] BAD_ADDR = 7'h24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe;
    wire  sda_line = m_sda & ~sda_oe;
    logic [7:0] ctrl;
    logic irq_n;
    logic warm_clr = 0, session_start = 0, card_present = 0, io_level = 1;
    logic card_active = 0, supply_fault = 0, prot_evt = 0, mute_evt = 0, early_evt = 0;

    cardif_host_regs u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .addr_sel_i(3'b101), .ctrl_o(ctrl), .warm_clr_i(warm_clr),
        .session_start_i(session_start), .card_present_i(card_present),
        .io_level_i(io_level), .card_active_i(card_active),
        .supply_fault_i(supply_fault), .prot_evt_i(prot_evt),
        .mute_evt_i(mute_evt), .early_evt_i(early_evt), .irq_n_o(irq_n)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    string      req_q[$];

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0 && exp_q.size() > 0)
                check(req_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1; m_scl = 1; ticks(HALF);
        m_sda = 0; ticks(HALF);
        m_scl = 0; ticks(HALF/2);
    endtask

    task automatic bus_stop();
        m_sda = 0; ticks(HALF);
        m_scl = 1; ticks(HALF);
        m_sda = 1; ticks(HALF);
    endtask

    task automatic bus_bit(input logic b, output logic seen, input bit inj);
        m_sda = b; ticks(HALF);
        m_scl = 1; ticks(HALF/2);
        seen = sda_line;
        if (inj) begin
            prot_evt = 1; ticks(1); prot_evt = 0; ticks(HALF/2 - 1);
        end else begin
            ticks(HALF/2);
        end
        m_scl = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s, 1'b0);
        bus_bit(1'b1, s, 1'b0);
        ack = ~s;
    endtask

    task automatic ctrl_write(input logic [6:0] a, input logic [7:0] d,
                              input logic exp_ack, input string req);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check({req, " addr ack"}, {7'b0, ack}, {7'b0, exp_ack});
        send_byte(d, ack);
        check({req, " data ack"}, {7'b0, ack}, {7'b0, exp_ack});
        bus_stop();
        ticks(4);
    endtask

    task automatic status_read(input logic [7:0] exp, input string req, input bit inj);
        logic ack, s;
        logic [7:0] v;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        check({req, " read addr ack"}, {7'b0, ack}, 8'h01);
        exp_q.push_back(exp);
        req_q.push_back(req);
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s, inj && (i == 3));
            v[i] = s;
        end
        bus_bit(1'b1, s, 1'b0); // master NACK
        bus_stop();
        act_q.push_back(v);
        ticks(4);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        ticks(5);
        rst = 0;
        ticks(5);
        // R4 reset state
        check("R4 ctrl reset", ctrl, 8'h00);
        check("R4 irq reset", {7'b0, irq_n}, 8'h01);
        check("R4 sda released", {7'b0, sda_oe}, 8'h00);
        status_read(8'h04, "R4 status reset", 0);

        // R2 control write
        ctrl_write(MY_ADDR, 8'hA5, 1'b1, "R2");
        check("R2 ctrl value", ctrl, 8'hA5);

        // R1 wrong address ignored
        ctrl_write(BAD_ADDR, 8'h3C, 1'b0, "R1 mismatch");
        check("R1 ctrl unchanged", ctrl, 8'hA5);

        // R8 warm reset cleared by sequencer
        ctrl_write(MY_ADDR, 8'hDA, 1'b1, "R8 setup");
        check("R8 ctrl written", ctrl, 8'hDA);
        warm_clr = 1; ticks(1); warm_clr = 0; ticks(2);
        check("R8 warm bit cleared", ctrl, 8'hD8);

        // R5 rising presence edge, R6 clear on read, R7 irq
        card_present = 1; ticks(3);
        check("R7 irq on presence change", {7'b0, irq_n}, 8'h00);
        status_read(8'h07, "R5 presence rise", 0);
        check("R7 irq released after read", {7'b0, irq_n}, 8'h01);
        status_read(8'h05, "R6 sticky cleared", 0);

        // R6 several stickies then read
        prot_evt = 1; mute_evt = 1; ticks(1); prot_evt = 0; mute_evt = 0; ticks(2);
        check("R7 irq on prot/mute", {7'b0, irq_n}, 8'h00);
        status_read(8'h35, "R3 prot and mute bits", 0);
        check("R6 irq released", {7'b0, irq_n}, 8'h01);

        // R6 session start clears early answer
        early_evt = 1; ticks(1); early_evt = 0; ticks(2);
        check("R7 irq on early", {7'b0, irq_n}, 8'h00);
        session_start = 1; ticks(1); session_start = 0; ticks(2);
        check("R6 session clears early irq", {7'b0, irq_n}, 8'h01);
        status_read(8'h05, "R6 session cleared", 0);

        // R7 supply fault level holds irq
        supply_fault = 1; ticks(3);
        status_read(8'h0D, "R3 supply fault bit", 0);
        check("R7 irq held by fault", {7'b0, irq_n}, 8'h00);
        supply_fault = 0; ticks(3);
        check("R7 irq held by sticky", {7'b0, irq_n}, 8'h00);
        status_read(8'h0D, "R6 supply sticky", 0);
        check("R7 irq released after fault", {7'b0, irq_n}, 8'h01);

        // R9 event during read kept
        status_read(8'h05, "R9 snapshot excludes late event", 1);
        check("R9 irq still low", {7'b0, irq_n}, 8'h00);
        status_read(8'h15, "R9 late event kept", 0);
        check("R9 irq released", {7'b0, irq_n}, 8'h01);

        // R5 falling presence edge
        card_present = 0; ticks(3);
        status_read(8'h06, "R5 presence fall", 0);

        // R3 live bits
        card_present = 1; card_active = 1; io_level = 0; ticks(3);
        status_read(8'h83, "R3 live bits", 0);
        status_read(8'h81, "R3 live bits stay", 0);
        io_level = 1; card_active = 0;

        // R10 bus still usable after NACKed reads
        ctrl_write(MY_ADDR, 8'h00, 1'b1, "R10 after reads");
        check("R10 ctrl rewritten", ctrl, 8'h00);

        while (act_q.size() > 0) ticks(1);
        ticks(4);
        finish_run();
    end

endmodule